// File: doc/BRIEF.md
# Parallel Peripheral Bus Target Phase Sequencer

This block is the target-side control engine for a narrow, parallel peripheral bus in the style of small-computer disk interfaces. It watches the shared busy and select lines to decide when the bus is idle. It answers an initiator that selects its identifier. It then carries a single connection through a fixed run of information phases, and gives the bus back when the connection is done.

Each byte moves with a four-step interlocked request/acknowledge handshake. The three phase-indicator outputs tell the initiator what the current byte means and which way it travels. The connection runs in this order:

- an identify message from the initiator;
- a six-byte command block from the initiator;
- a variable number of data bytes to the initiator;
- one status byte;
- a final command-complete message.

The received message and command bytes leave the block through a one-cycle strobe. Outgoing data bytes are fetched by index from a neighbouring buffer. The data-in length and the status value are taken from input ports when the target is selected.

Top module: `psq_target`

## Requirements
- R1: While reset is held and right after it is released, `bsy_o`, `req_o`, `msg_o`, `cd_o`, `io_o`, `data_oe_o`, `rx_valid_o` and `bus_free_o` are all 0.
- R2: `bus_free_o` rises only after `sel_i` and the combined busy (`bsy_i` or `bsy_o`) have both been low on SETTLE consecutive rising clock edges. It falls in the same cycle that either line goes high, with no clock edge needed.
- R3: The target answers selection only when, at a clock edge, `sel_i`=1, `bsy_i`=0 and bit OWN_ID of `data_i` is 1. It raises `bsy_o` at that edge. A clear ID bit, or `bsy_i` high, leaves `bsy_o` at 0.
- R4: After `sel_i` falls, the phase lines {`msg_o`,`cd_o`,`io_o`} step through message out 110, command 010, data in 001, status 011 and message in 111. They never change while `req_o` is high.
- R5: Every byte uses a four-step handshake: `req_o` rises, the initiator raises `ack_i`, `req_o` falls at the first edge that sees `ack_i` high, and no new `req_o` rises until `ack_i` has been seen low.
- R6: The command phase moves exactly CMD_LEN bytes. Each byte received in message out and in command raises `rx_valid_o` for one cycle, with `rx_data_o` holding the `data_i` value seen when `ack_i` was first high.
- R7: In the data-in phase, byte k is `rd_byte_i` as presented while `rd_idx_o`=k, for k from 0 to length-1. `data_oe_o` is 1 in every phase whose `io_o` is 1, and `data_o` stays stable while `req_o` is high.
- R8: The status byte equals `status_i` as sampled at selection. The message-in byte is 8'h00 (command complete).
- R9: A data-in length of 0, sampled from `xfer_len_i` at selection, skips the data-in phase, so status follows command directly.
- R10: `bsy_o` falls at the edge that sees `ack_i` low after the message-in byte. The phase lines return to 000, and a later selection is answered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Select line from the bus |
| bsy_i | input | 1 | Busy as driven by other devices |
| ack_i | input | 1 | Acknowledge from the initiator |
| data_i | input | 8 | Bus data as seen by the target |
| xfer_len_i | input | LEN_W | Data-in byte count, sampled at selection |
| status_i | input | 8 | Status byte, sampled at selection |
| rd_byte_i | input | 8 | Data-in byte for index `rd_idx_o` |
| rd_idx_o | output | LEN_W | Index of the data-in byte being fetched |
| bus_free_o | output | 1 | Bus idle after the settle interval |
| bsy_o | output | 1 | Busy driven by this target |
| req_o | output | 1 | Byte request |
| msg_o | output | 1 | Message phase indicator |
| cd_o | output | 1 | Command/data phase indicator |
| io_o | output | 1 | Direction indicator, 1 = target to initiator |
| data_o | output | 8 | Byte driven by the target |
| data_oe_o | output | 1 | Enable for `data_o` onto the bus |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | 8 | Received byte |

## Verification
The assertions check, on every cycle, the local handshake and phase rules:

- `req_o` falls only after `ack_i`;
- the phase lines and the outgoing byte hold while a request is pending;
- busy rises only on a valid selection and drops only after message in;
- the idle flag is never raised straight after bus activity.

Only the bench scenarios can show the global behaviour:

- the exact order and count of phases for each data length, including zero;
- the byte values in each phase and the strobed command bytes;
- the exact settle count before the idle flag;
- the refusal of selections with the wrong identifier or while the bus is busy.

// File: rtl/psq_pkg.sv
`timescale 1ns/100ps
package psq_pkg;

    // Phase lines {msg, cd, io}; io = 1 means target to initiator
    typedef enum logic [2:0] {
        PH_DOUT = 3'b000,
        PH_DIN  = 3'b001,
        PH_CMD  = 3'b010,
        PH_STAT = 3'b011,
        PH_MOUT = 3'b110,
        PH_MIN  = 3'b111
    } phase_e;

    typedef enum logic [1:0] {
        CN_IDLE,
        CN_SEL,
        CN_RUN
    } conn_e;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_SETUP,
        HS_REQ,
        HS_DROP
    } hs_e;

    localparam logic [7:0] MSG_CMD_DONE = 8'h00;

endpackage

// File: rtl/psq_free_det.sv
`timescale 1ns/100ps
module psq_free_det #(
    parameter int SETTLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic bsy_i,
    output logic free_o
);
    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             quiet;

    assign quiet = !sel_i && !bsy_i;

    always_comb begin
        cnt_d = cnt_q;
        if (!quiet) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign free_o = (cnt_q == LIMIT) && quiet;

    // R2
    free_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_o |-> $past(!sel_i && !bsy_i));

endmodule

// File: rtl/psq_byte_hs.sv
`timescale 1ns/100ps
module psq_byte_hs
    import psq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       ack_i,
    input  logic [7:0] bus_data_i,
    output logic       req_o,
    output logic [7:0] data_o,
    output logic [7:0] rx_o,
    output logic       idle_o,
    output logic       done_o
);
    typedef struct packed {
        hs_e        st;
        logic [7:0] tx;
        logic [7:0] rx;
    } hs_t;

    hs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        done_o = 1'b0;
        unique case (r_q.st)
            HS_IDLE: begin
                if (start_i) begin
                    r_d.st = HS_SETUP;
                    r_d.tx = tx_i;
                end
            end
            HS_SETUP: r_d.st = HS_REQ;
            HS_REQ: begin
                if (ack_i) begin
                    r_d.st = HS_DROP;
                    r_d.rx = bus_data_i;
                end
            end
            HS_DROP: begin
                if (!ack_i) begin
                    r_d.st = HS_IDLE;
                    done_o = 1'b1;
                end
            end
            default: r_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: HS_IDLE, tx: 8'h00, rx: 8'h00};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_o  = (r_q.st == HS_REQ);
    assign data_o = r_q.tx;
    assign rx_o   = r_q.rx;
    assign idle_o = (r_q.st == HS_IDLE);

    // R5
    req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> $past(ack_i));

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $stable(data_o));

endmodule

// File: rtl/psq_target.sv
`timescale 1ns/100ps
module psq_target
    import psq_pkg::*;
#(
    parameter int OWN_ID  = 7,
    parameter int SETTLE  = 16,
    parameter int CMD_LEN = 6,
    parameter int LEN_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             bsy_i,
    input  logic             ack_i,
    input  logic [7:0]       data_i,
    input  logic [LEN_W-1:0] xfer_len_i,
    input  logic [7:0]       status_i,
    input  logic [7:0]       rd_byte_i,
    output logic [LEN_W-1:0] rd_idx_o,
    output logic             bus_free_o,
    output logic             bsy_o,
    output logic             req_o,
    output logic             msg_o,
    output logic             cd_o,
    output logic             io_o,
    output logic [7:0]       data_o,
    output logic             data_oe_o,
    output logic             rx_valid_o,
    output logic [7:0]       rx_data_o
);
    localparam int CMD_W = $clog2(CMD_LEN + 1);
    localparam int CNT_W = (LEN_W > CMD_W) ? LEN_W : CMD_W;
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_LEN - 1);

    typedef struct packed {
        conn_e            st;
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [7:0]       stat;
    } ctl_t;

    ctl_t       c_d, c_q;
    logic       hs_start, hs_idle, hs_done;
    logic [7:0] hs_tx, hs_rx;
    logic [2:0] ph_lines;
    logic       own_sel;
    logic [CNT_W-1:0] cnt_inc;

    assign own_sel = sel_i && !bsy_i && data_i[OWN_ID];
    assign cnt_inc = c_q.cnt + 1'b1;

    always_comb begin
        c_d      = c_q;
        hs_start = 1'b0;
        hs_tx    = 8'h00;
        unique case (c_q.st)
            CN_IDLE: begin
                if (own_sel) begin
                    c_d.st   = CN_SEL;
                    c_d.len  = xfer_len_i;
                    c_d.stat = status_i;
                end
            end
            CN_SEL: begin
                if (!sel_i) begin
                    c_d.st  = CN_RUN;
                    c_d.ph  = PH_MOUT;
                    c_d.cnt = '0;
                end
            end
            CN_RUN: begin
                hs_start = hs_idle;
                unique case (c_q.ph)
                    PH_DIN:  hs_tx = rd_byte_i;
                    PH_STAT: hs_tx = c_q.stat;
                    PH_MIN:  hs_tx = MSG_CMD_DONE;
                    default: hs_tx = 8'h00;
                endcase
                if (hs_done) begin
                    unique case (c_q.ph)
                        PH_MOUT: begin
                            c_d.ph  = PH_CMD;
                            c_d.cnt = '0;
                        end
                        PH_CMD: begin
                            if (c_q.cnt == CMD_LAST) begin
                                c_d.ph  = (c_q.len != '0) ? PH_DIN : PH_STAT;
                                c_d.cnt = '0;
                            end else begin
                                c_d.cnt = cnt_inc;
                            end
                        end
                        PH_DIN: begin
                            if (cnt_inc == CNT_W'(c_q.len)) begin
                                c_d.ph  = PH_STAT;
                                c_d.cnt = '0;
                            end else begin
                                c_d.cnt = cnt_inc;
                            end
                        end
                        PH_STAT: c_d.ph = PH_MIN;
                        default: begin
                            c_d.st  = CN_IDLE;
                            c_d.ph  = PH_DOUT;
                            c_d.cnt = '0;
                        end
                    endcase
                end
            end
            default: c_d.st = CN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: CN_IDLE, ph: PH_DOUT, cnt: '0, len: '0, stat: 8'h00};
        end else begin
            c_q <= c_d;
        end
    end

    psq_byte_hs u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (hs_start),
        .tx_i       (hs_tx),
        .ack_i      (ack_i),
        .bus_data_i (data_i),
        .req_o      (req_o),
        .data_o     (data_o),
        .rx_o       (hs_rx),
        .idle_o     (hs_idle),
        .done_o     (hs_done)
    );

    psq_free_det #(.SETTLE(SETTLE)) u_free (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel_i),
        .bsy_i  (bsy_i || bsy_o),
        .free_o (bus_free_o)
    );

    assign ph_lines   = (c_q.st == CN_RUN) ? c_q.ph : 3'b000;
    assign msg_o      = ph_lines[2];
    assign cd_o       = ph_lines[1];
    assign io_o       = ph_lines[0];
    assign bsy_o      = (c_q.st != CN_IDLE);
    assign data_oe_o  = (c_q.st == CN_RUN) && c_q.ph[0];
    assign rx_valid_o = hs_done && !c_q.ph[0];
    assign rx_data_o  = hs_rx;
    assign rd_idx_o   = c_q.cnt[LEN_W-1:0];

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(req_o)) |-> $stable({msg_o, cd_o, io_o}));

    // R3
    sel_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_o) |-> $past(sel_i && !bsy_i && data_i[OWN_ID]));

    // R10
    bsy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bsy_o) |-> $past({msg_o, cd_o, io_o} == 3'b111));

    // R5
    req_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> bsy_o);

endmodule

// File: tb/tb_psq_target.sv
`timescale 1ns/100ps
module tb_psq_target;
    localparam int SETTLE = 4;
    localparam int OWN    = 3;
    localparam int CMDN   = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_i, bsy_i, ack_i;
    logic [7:0] data_i, xfer_len_i, status_i, rd_byte_i, rd_idx_o;
    logic       bus_free_o, bsy_o, req_o, msg_o, cd_o, io_o, data_oe_o, rx_valid_o;
    logic [7:0] data_o, rx_data_o;

    always #2.5 clk = ~clk;

    psq_target #(.OWN_ID(OWN), .SETTLE(SETTLE), .CMD_LEN(CMDN), .LEN_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .bsy_i(bsy_i), .ack_i(ack_i),
        .data_i(data_i), .xfer_len_i(xfer_len_i), .status_i(status_i),
        .rd_byte_i(rd_byte_i), .rd_idx_o(rd_idx_o), .bus_free_o(bus_free_o),
        .bsy_o(bsy_o), .req_o(req_o), .msg_o(msg_o), .cd_o(cd_o), .io_o(io_o),
        .data_o(data_o), .data_oe_o(data_oe_o), .rx_valid_o(rx_valid_o),
        .rx_data_o(rx_data_o)
    );

    assign rd_byte_i = rd_idx_o * 8'd37 + 8'h5A;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rxlog [0:255];
    int rxn = 0;

    always @(posedge clk) begin
        if (rx_valid_o && rxn < 256) begin
            rxlog[rxn] <= rx_data_o;
            rxn <= rxn + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [2:0] ph, input logic [7:0] val, input string req);
        int n;
        n = 0;
        while (!req_o && n < 64) begin
            @(negedge clk);
            n++;
        end
        chk(req_o == 1'b1, "R5 request seen", req_o, 1);
        chk({msg_o, cd_o, io_o} == ph, "R4 phase lines", {msg_o, cd_o, io_o}, ph);
        if (ph[0]) begin
            chk(data_oe_o == 1'b1, "R7 data enable", data_oe_o, 1);
            chk(data_o == val, req, data_o, val);
        end else begin
            data_i = val;
        end
        ack_i = 1'b1;
        @(negedge clk);
        chk(req_o == 1'b0, "R5 request drops after ack", req_o, 0);
        @(negedge clk);
        chk(req_o == 1'b0, "R5 no request while ack high", req_o, 0);
        ack_i  = 1'b0;
        data_i = 8'h00;
    endtask

    task automatic conn(input int len, input logic [7:0] stat, input logic [7:0] seed);
        int base;
        xfer_len_i = 8'(len);
        status_i   = stat;
        @(negedge clk);
        data_i = 8'(1 << OWN) | 8'h01;
        sel_i  = 1'b1;
        @(negedge clk);
        chk(bsy_o == 1'b1, "R3 busy after selection", bsy_o, 1);
        chk(req_o == 1'b0, "R3 no request during selection", req_o, 0);
        xfer_len_i = 8'hFF;
        status_i   = 8'hEE;
        sel_i  = 1'b0;
        data_i = 8'h00;
        base = rxn;
        xfer(3'b110, 8'hC0 | seed, "R6");
        for (int k = 0; k < CMDN; k++) xfer(3'b010, 8'(seed * 16 + k), "R6");
        for (int k = 0; k < len; k++) xfer(3'b001, 8'(k * 37 + 8'h5A), "R7 data byte");
        xfer(3'b011, stat, "R8 status byte");
        xfer(3'b111, 8'h00, "R8 complete message");
        @(negedge clk);
        chk(bsy_o == 1'b0, "R10 busy released", bsy_o, 0);
        chk({msg_o, cd_o, io_o} == 3'b000, "R10 phase cleared", {msg_o, cd_o, io_o}, 0);
        chk(rxn - base == CMDN + 1, "R6 received byte count", rxn - base, CMDN + 1);
        if (rxn - base == CMDN + 1) begin
            chk(rxlog[base] == (8'hC0 | seed), "R6 identify byte", rxlog[base], 8'hC0 | seed);
            for (int k = 0; k < CMDN; k++)
                chk(rxlog[base + 1 + k] == 8'(seed * 16 + k), "R6 command byte",
                    rxlog[base + 1 + k], 8'(seed * 16 + k));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sel_i = 1'b0;
        bsy_i = 1'b0;
        ack_i = 1'b0;
        data_i = 8'h00;
        xfer_len_i = 8'h00;
        status_i = 8'h00;
        repeat (3) @(negedge clk);
        chk({bsy_o, req_o, msg_o, cd_o, io_o, data_oe_o, rx_valid_o, bus_free_o} == 8'h00,
            "R1 reset outputs", {bsy_o, req_o, msg_o, cd_o, io_o, data_oe_o, rx_valid_o, bus_free_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({bsy_o, req_o, data_oe_o} == 3'b000, "R1 after release", {bsy_o, req_o, data_oe_o}, 0);

        // R2: settle sweep, alternating which line was last active
        for (int k = 0; k <= SETTLE + 2; k++) begin
            if (k % 2 == 0) bsy_i = 1'b1; else sel_i = 1'b1;
            @(negedge clk);
            bsy_i = 1'b0;
            sel_i = 1'b0;
            repeat (k) @(negedge clk);
            chk(bus_free_o == (k >= SETTLE), "R2 settle count", bus_free_o, k >= SETTLE);
        end
        bsy_i = 1'b1;
        #1;
        chk(bus_free_o == 1'b0, "R2 free ends on busy", bus_free_o, 0);
        @(negedge clk);
        bsy_i = 1'b0;
        repeat (SETTLE) @(negedge clk);
        sel_i = 1'b1;
        #1;
        chk(bus_free_o == 1'b0, "R2 free ends on select", bus_free_o, 0);
        sel_i = 1'b0;

        // R3: selections that must be ignored
        @(negedge clk);
        data_i = 8'hFF & ~8'(1 << OWN);
        sel_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(bsy_o == 1'b0, "R3 wrong id ignored", bsy_o, 0);
        data_i = 8'(1 << OWN);
        bsy_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(bsy_o == 1'b0, "R3 busy bus ignored", bsy_o, 0);
        chk(req_o == 1'b0, "R3 no request when ignored", req_o, 0);
        sel_i = 1'b0;
        bsy_i = 1'b0;
        data_i = 8'h00;
        @(negedge clk);

        // R4 R7 R8 R9 R10: full connections over a sweep of lengths
        for (int len = 0; len <= 5; len++) begin
            conn(len, 8'(len * 17 + 3), 8'(len + 1));
            repeat (2) @(negedge clk);
        end
        conn(0, 8'h02, 8'h0A);
        repeat (SETTLE + 1) @(negedge clk);
        chk(bus_free_o == 1'b1, "R2 free after connection", bus_free_o, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule